// File: doc/BRIEF.md
# Muxed General-Purpose I/O Port

This block is a register-programmed I/O port that sits on an APB bus as a slave. It has a 10-bit word address and read and write data as wide as the port, which is 8 bits by default. Each pin has its own pad output and an active-low pad output enable. Bit by bit, a select register hands control of a pin either to software or to an on-chip peripheral. Software control uses a data register and a direction register. Peripheral control uses the peripheral's own data and active-low enable inputs. The pad inputs are treated as asynchronous. A two-stage synchroniser brings them into the bus clock domain. The synchronised value is readable through the data offset, and the block also always returns it to the peripheral.

Each pin has interrupt detection. It can sense a rising edge, a falling edge, both edges, a high level or a low level. Edge events are latched in a raw status and cleared by writing ones. Level events follow the pin. A mask gates the raw status onto one masked interrupt line per pin, and a combined line is the OR of the masked lines. An integration-test mode hands the pad outputs, the enables, the peripheral data outputs and both kinds of interrupt line to dedicated test registers, so that the wiring can be checked without normal operation.

A small bus state machine has three states. IDLE goes to SETUP on select without enable. SETUP goes to ACCESS on select with enable, stays in SETUP while select holds without enable, and goes back to IDLE when select drops. ACCESS goes to SETUP on a new select without enable, and otherwise goes back to IDLE. A write takes effect only on the SETUP-to-ACCESS transition.

Top module: `gpio_altfunc`

## Requirements
- R1: Writes land in the cycle where select and enable are both high. These offsets read back the last value written: 0x001 direction (1 = output), 0x002 sense (1 = level, 0 = edge), 0x003 both-edges, 0x004 event (1 = rising or high, 0 = falling or low), 0x005 interrupt mask, 0x009 peripheral select, 0x00A test control (bit 0 enables test mode, bit 1 is the combined interrupt value in test mode), 0x00B test pad out, 0x00C test pad enable, 0x00D test peripheral data, 0x00E test interrupt lines.
- R2: Active-low reset clears every register. After reset the pad outputs are 0, every pad enable is high (inactive), and both interrupt outputs are low.
- R3: A pad input change appears on the peripheral data output, and in a read of offset 0x000, after exactly two rising clock edges. After one edge the old value is still shown.
- R4: When a pin's select bit is 0, its pad output equals its bit in the data register (written at 0x000), and its pad enable is the inverse of its direction bit.
- R5: When a pin's select bit is 1, its pad output and pad enable come from the peripheral data input and the peripheral active-low enable input. If those enables are tied high and the direction is 0, every pad enable stays high.
- R6: In edge sense, the raw status bit (read at 0x006) is set by the selected edge: rising when event = 1, falling when event = 0, either edge when both-edges = 1. It stays set until a 1 is written to that bit at 0x008.
- R7: In level sense, the raw status bit follows whether the synchronised pin is at the selected level, with no latching.
- R8: Each masked interrupt line, also readable at 0x007, is its raw bit ANDed with its mask bit. The combined interrupt is high exactly when any masked line is high.
- R9: In test mode, the pad outputs, the pad enables, the peripheral data outputs and the masked interrupt lines equal the test registers. The combined interrupt equals test control bit 1. Clearing test mode restores normal operation.
- R10: Reads of unmapped offsets and of the write-only clear offset 0x008 return 0. Writes to unmapped offsets change no register.
- R11: A setup phase that is not followed by an enable phase writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| paddr | input | 10 | Word address (byte address bits 11:2) |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data |
| pad_in | input | 8 | Asynchronous pad inputs |
| pad_out | output | 8 | Pad output data |
| pad_oe_n | output | 8 | Pad output enable, active low |
| per_out | input | 8 | Peripheral data to drive onto pads |
| per_oe_n | input | 8 | Peripheral pad enable, active low |
| per_in | output | 8 | Synchronised pad inputs returned to the peripheral |
| irq_mis | output | 8 | Masked interrupt lines, one per pin |
| irq_any | output | 1 | OR of the masked interrupt lines |

## Verification
Edge status latched behind a mask is the hardest situation to reach from the ports. The pin has to toggle while its mask is 0, and the event only shows once the mask is opened later. A stale edge can also survive a change of configuration, so the stimulus clears the raw status after each configuration step. It then drives the pad, waits out the synchroniser and edge register, and checks the masked lines, the raw read-back and the result of a write-one clear. Random rounds of select, data, direction and peripheral drive are checked against a bench model of the pin multiplexer. Separate rounds check random pad values read back through the synchroniser.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } bus_state_t;

    localparam int OFS_DATA  = 0;
    localparam int OFS_DIR   = 1;
    localparam int OFS_SENSE = 2;
    localparam int OFS_BOTH  = 3;
    localparam int OFS_EVENT = 4;
    localparam int OFS_MASK  = 5;
    localparam int OFS_RAW   = 6;
    localparam int OFS_MIS   = 7;
    localparam int OFS_CLR   = 8;
    localparam int OFS_AFSEL = 9;
    localparam int OFS_TCTRL = 10;
    localparam int OFS_TPAD  = 11;
    localparam int OFS_TOE   = 12;
    localparam int OFS_TAF   = 13;
    localparam int OFS_TIRQ  = 14;
endpackage

// File: rtl/gpio_bus_fsm.sv
`timescale 1ns/1ps
module gpio_bus_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_en
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (psel && !penable) state_d = ST_SETUP;
            ST_SETUP:  begin
                if (!psel)        state_d = ST_IDLE;
                else if (penable) state_d = ST_ACCESS;
            end
            ST_ACCESS: state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_en = (state_q == ST_SETUP) && psel && penable && pwrite;
    end
endmodule

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain_q[s] <= '0;
            else if (s == 0) chain_q[s] <= async_in;
            else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq.sv
`timescale 1ns/1ps
module gpio_irq #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    input  logic [WIDTH-1:0] sense_lvl,
    input  logic [WIDTH-1:0] both_edge,
    input  logic [WIDTH-1:0] event_hi,
    input  logic             clr_wr,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] raw
);
    logic [WIDTH-1:0] prev_q, raw_q;
    logic [WIDTH-1:0] edge_hit, lvl_hit, clr_mask;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic rise, fall;
        assign rise        = pin[i] & ~prev_q[i];
        assign fall        = ~pin[i] & prev_q[i];
        assign edge_hit[i] = ~sense_lvl[i] &
                             (both_edge[i] ? (rise | fall) : (event_hi[i] ? rise : fall));
        assign lvl_hit[i]  = event_hi[i] ? pin[i] : ~pin[i];
        assign raw[i]      = sense_lvl[i] ? lvl_hit[i] : raw_q[i];
    end

    assign clr_mask = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            raw_q  <= '0;
        end else begin
            prev_q <= pin;
            raw_q  <= (raw_q & ~clr_mask) | edge_hit;
        end
    end
endmodule

// File: rtl/gpio_altfunc.sv
`timescale 1ns/1ps
module gpio_altfunc
    import gpio_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [PINS-1:0]   pwdata,
    output logic [PINS-1:0]   prdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe_n,
    input  logic [PINS-1:0]   per_out,
    input  logic [PINS-1:0]   per_oe_n,
    output logic [PINS-1:0]   per_in,
    output logic [PINS-1:0]   irq_mis,
    output logic              irq_any
);
    localparam int TCTRL_W = 2;

    logic              wr_en, clr_wr;
    logic [PINS-1:0]   pin_sync, raw, mis_fn;
    logic [PINS-1:0]   data_q, dir_q, sense_q, both_q, event_q, mask_q, afsel_q;
    logic [PINS-1:0]   t_pad_q, t_oe_q, t_af_q, t_irq_q;
    logic [TCTRL_W-1:0] tctrl_q;
    logic              test_mode;

    gpio_bus_fsm u_fsm (
        .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .wr_en(wr_en)
    );

    gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(pclk), .rst_n(presetn), .async_in(pad_in), .sync_out(pin_sync)
    );

    assign clr_wr = wr_en && (paddr == ADDR_W'(OFS_CLR));

    gpio_irq #(.WIDTH(PINS)) u_irq (
        .clk(pclk), .rst_n(presetn), .pin(pin_sync), .sense_lvl(sense_q),
        .both_edge(both_q), .event_hi(event_q), .clr_wr(clr_wr),
        .clr_bits(pwdata), .raw(raw)
    );

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            data_q  <= '0; dir_q  <= '0; sense_q <= '0; both_q <= '0;
            event_q <= '0; mask_q <= '0; afsel_q <= '0; tctrl_q <= '0;
            t_pad_q <= '0; t_oe_q <= '0; t_af_q  <= '0; t_irq_q <= '0;
        end else if (wr_en) begin
            case (paddr)
                ADDR_W'(OFS_DATA):  data_q  <= pwdata;
                ADDR_W'(OFS_DIR):   dir_q   <= pwdata;
                ADDR_W'(OFS_SENSE): sense_q <= pwdata;
                ADDR_W'(OFS_BOTH):  both_q  <= pwdata;
                ADDR_W'(OFS_EVENT): event_q <= pwdata;
                ADDR_W'(OFS_MASK):  mask_q  <= pwdata;
                ADDR_W'(OFS_AFSEL): afsel_q <= pwdata;
                ADDR_W'(OFS_TCTRL): tctrl_q <= pwdata[TCTRL_W-1:0];
                ADDR_W'(OFS_TPAD):  t_pad_q <= pwdata;
                ADDR_W'(OFS_TOE):   t_oe_q  <= pwdata;
                ADDR_W'(OFS_TAF):   t_af_q  <= pwdata;
                ADDR_W'(OFS_TIRQ):  t_irq_q <= pwdata;
                default: ;
            endcase
        end
    end

    assign test_mode = tctrl_q[0];
    assign mis_fn    = raw & mask_q;

    for (genvar i = 0; i < PINS; i++) begin : g_mux
        logic fn_out, fn_oe_n;
        assign fn_out      = afsel_q[i] ? per_out[i]  : data_q[i];
        assign fn_oe_n     = afsel_q[i] ? per_oe_n[i] : ~dir_q[i];
        assign pad_out[i]  = test_mode ? t_pad_q[i] : fn_out;
        assign pad_oe_n[i] = test_mode ? t_oe_q[i]  : fn_oe_n;
        assign per_in[i]   = test_mode ? t_af_q[i]  : pin_sync[i];
        assign irq_mis[i]  = test_mode ? t_irq_q[i] : mis_fn[i];
    end

    assign irq_any = test_mode ? tctrl_q[1] : |mis_fn;

    always_comb begin
        case (paddr)
            ADDR_W'(OFS_DATA):  prdata = pin_sync;
            ADDR_W'(OFS_DIR):   prdata = dir_q;
            ADDR_W'(OFS_SENSE): prdata = sense_q;
            ADDR_W'(OFS_BOTH):  prdata = both_q;
            ADDR_W'(OFS_EVENT): prdata = event_q;
            ADDR_W'(OFS_MASK):  prdata = mask_q;
            ADDR_W'(OFS_RAW):   prdata = raw;
            ADDR_W'(OFS_MIS):   prdata = mis_fn;
            ADDR_W'(OFS_AFSEL): prdata = afsel_q;
            ADDR_W'(OFS_TCTRL): prdata = PINS'(tctrl_q);
            ADDR_W'(OFS_TPAD):  prdata = t_pad_q;
            ADDR_W'(OFS_TOE):   prdata = t_oe_q;
            ADDR_W'(OFS_TAF):   prdata = t_af_q;
            ADDR_W'(OFS_TIRQ):  prdata = t_irq_q;
            default:            prdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_altfunc_chk.sv
`timescale 1ns/1ps
module gpio_altfunc_chk #(
    parameter int PINS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            psel,
    input logic            penable,
    input logic [PINS-1:0] pad_in,
    input logic [PINS-1:0] per_in,
    input logic [PINS-1:0] pad_out,
    input logic [PINS-1:0] pad_oe_n,
    input logic [PINS-1:0] per_oe_n,
    input logic [PINS-1:0] afsel,
    input logic [PINS-1:0] dir,
    input logic [PINS-1:0] t_pad,
    input logic [PINS-1:0] irq_mis,
    input logic            irq_any,
    input logic            tmode
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r11_enable_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable) |-> $past(psel && !penable));

    a_r3_two_edge_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !tmode) |-> (per_in == $past(pad_in, 2)));

    a_r5_tied_high_stays_input: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmode && dir == '0 && (&per_oe_n)) |-> (&pad_oe_n));

    a_r4_sw_pin_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmode && afsel == '0) |-> (pad_oe_n == ~dir));

    a_r8_combined_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !tmode |-> (irq_any == (irq_mis != '0)));

    a_r9_test_pad_override: assert property (@(posedge clk) disable iff (!rst_n)
        tmode |-> (pad_out == t_pad));
endmodule

bind gpio_altfunc gpio_altfunc_chk #(.PINS(PINS)) u_chk (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
    .pad_in(pad_in), .per_in(per_in), .pad_out(pad_out), .pad_oe_n(pad_oe_n),
    .per_oe_n(per_oe_n), .afsel(afsel_q), .dir(dir_q), .t_pad(t_pad_q),
    .irq_mis(irq_mis), .irq_any(irq_any), .tmode(test_mode)
);

// File: tb/test_gpio_altfunc.sv
`timescale 1ns/1ps
module test_gpio_altfunc;
    logic       pclk = 1'b0;
    logic       presetn = 1'b0;
    logic [9:0] paddr = '0;
    logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0] pwdata = '0, prdata;
    logic [7:0] pad_in = '0, pad_out, pad_oe_n;
    logic [7:0] per_out = '0, per_oe_n = 8'hFF, per_in;
    logic [7:0] irq_mis;
    logic       irq_any;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 pclk = ~pclk;

    gpio_altfunc i_gpio_altfunc (
        .pclk(pclk), .presetn(presetn), .paddr(paddr), .psel(psel),
        .penable(penable), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe_n(pad_oe_n),
        .per_out(per_out), .per_oe_n(per_oe_n), .per_in(per_in),
        .irq_mis(irq_mis), .irq_any(irq_any)
    );

    function automatic logic [7:0] exp_pad(input logic [7:0] sel, dat, pdat);
        return (sel & pdat) | (~sel & dat);
    endfunction

    function automatic logic [7:0] exp_oe(input logic [7:0] sel, dr, poe);
        return (sel & poe) | (~sel & ~dr);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [7:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 10'(a); pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [7:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 10'(a);
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge pclk);
        #1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] sel, dat, dr;
        void'($urandom(32'h5EED_0C61));
        repeat (3) @(negedge pclk);
        #1;
        // R2 reset state
        check("R2 pad_out", pad_out, 8'h00);
        check("R2 pad_oe_n", pad_oe_n, 8'hFF);
        check("R2 irq_any", irq_any, 0);
        presetn = 1'b1;
        settle(2);
        bus_rd(1, rd);  check("R2 dir reset", rd, 8'h00);
        bus_rd(9, rd);  check("R2 afsel reset", rd, 8'h00);

        // R1 read-back of configuration and test registers
        for (int a = 1; a <= 14; a++) begin
            logic [7:0] v, mask;
            if (a >= 6 && a <= 8) continue;
            v = 8'($urandom);
            if (a == 10) v = {6'b0, v[1], 1'b0};
            mask = 8'hFF;
            bus_wr(a, v);
            bus_rd(a, rd);
            check($sformatf("R1 readback ofs %0d", a), rd & mask, v);
        end
        for (int a = 1; a <= 14; a++) if (a != 6 && a != 7 && a != 8) bus_wr(a, 8'h00);

        // R11 setup without enable writes nothing
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; paddr = 10'd1; pwdata = 8'hFF;
        @(negedge pclk);
        psel = 1'b0; pwrite = 1'b0;
        bus_rd(1, rd); check("R11 no write without enable", rd, 8'h00);

        // R3 synchroniser latency, boundary
        @(negedge pclk); pad_in = 8'h3C;
        @(posedge pclk); #1 check("R3 one edge old value", per_in, 8'h00);
        @(posedge pclk); #1 check("R3 two edges new value", per_in, 8'h3C);
        for (int k = 0; k < 10; k++) begin
            logic [7:0] v;
            v = 8'($urandom);
            @(negedge pclk); pad_in = v;
            bus_rd(0, rd);
            check("R3 data read synced", rd, v);
        end

        // R4/R5 random mux rounds
        for (int k = 0; k < 30; k++) begin
            sel = 8'($urandom); dat = 8'($urandom); dr = 8'($urandom);
            if (k == 0) sel = 8'h00;
            if (k == 1) sel = 8'hFF;
            bus_wr(9, sel); bus_wr(0, dat); bus_wr(1, dr);
            @(negedge pclk);
            per_out = 8'($urandom); per_oe_n = 8'($urandom);
            #1;
            check("R4/R5 pad_out", pad_out, exp_pad(sel, dat, per_out));
            check("R4/R5 pad_oe_n", pad_oe_n, exp_oe(sel, dr, per_oe_n));
        end
        // R5 tied-high peripheral enable keeps pins as inputs
        bus_wr(1, 8'h00); bus_wr(9, 8'hFF);
        @(negedge pclk); per_oe_n = 8'hFF; #1;
        check("R5 tied high input", pad_oe_n, 8'hFF);
        bus_wr(9, 8'h00);

        // R6 rising edge on pin 0
        @(negedge pclk); pad_in = 8'h00; settle(4);
        bus_wr(2, 8'h00); bus_wr(3, 8'h00); bus_wr(4, 8'h01); bus_wr(5, 8'h01);
        bus_wr(8, 8'hFF);
        check("R6 idle no irq", irq_any, 0);
        @(negedge pclk); pad_in = 8'h01; settle(4);
        check("R6 rising mis", irq_mis, 8'h01);
        check("R8 combined high", irq_any, 1);
        bus_rd(6, rd); check("R6 raw read", rd, 8'h01);
        @(negedge pclk); pad_in = 8'h00; settle(4);
        check("R6 edge latched after pin low", irq_mis, 8'h01);
        bus_wr(8, 8'h01); settle(1);
        check("R6 w1c clears", irq_mis, 8'h00);
        bus_rd(8, rd); check("R10 clear offset reads zero", rd, 8'h00);

        // R6 falling edge on pin 0
        bus_wr(4, 8'h00);
        @(negedge pclk); pad_in = 8'h01; settle(4);
        bus_wr(8, 8'hFF); settle(1);
        check("R6 rise ignored in falling mode", irq_mis, 8'h00);
        @(negedge pclk); pad_in = 8'h00; settle(4);
        check("R6 falling mis", irq_mis, 8'h01);
        bus_wr(8, 8'hFF);

        // R6 both edges on pin 1
        bus_wr(3, 8'h02); bus_wr(5, 8'h02); bus_wr(8, 8'hFF);
        @(negedge pclk); pad_in = 8'h02; settle(4);
        check("R6 both rise", irq_mis, 8'h02);
        bus_wr(8, 8'h02); settle(1);
        check("R6 both cleared", irq_mis, 8'h00);
        @(negedge pclk); pad_in = 8'h00; settle(4);
        check("R6 both fall", irq_mis, 8'h02);
        bus_wr(8, 8'hFF); bus_wr(3, 8'h00);

        // R7 level high on pin 2, level low on pin 3
        bus_wr(2, 8'h0C); bus_wr(4, 8'h04); bus_wr(5, 8'h0C); settle(1);
        check("R7 low level active", irq_mis, 8'h08);
        @(negedge pclk); pad_in = 8'h0C; settle(4);
        check("R7 high level active", irq_mis, 8'h04);
        @(negedge pclk); pad_in = 8'h08; settle(4);
        check("R7 level not latched", irq_mis, 8'h00);
        check("R8 combined low", irq_any, 0);
        bus_wr(2, 8'h00); @(negedge pclk); pad_in = 8'h00; settle(4);

        // R8 masked event appears when mask opens
        bus_wr(4, 8'h01); bus_wr(5, 8'h00); bus_wr(8, 8'hFF);
        @(negedge pclk); pad_in = 8'h01; settle(4);
        check("R8 masked line low", irq_mis, 8'h00);
        check("R8 masked combined low", irq_any, 0);
        bus_rd(6, rd); check("R8 raw still set", rd, 8'h01);
        bus_wr(5, 8'h01); settle(1);
        check("R8 mask opens", irq_mis, 8'h01);
        bus_rd(7, rd); check("R8 mis read", rd, 8'h01);
        bus_wr(8, 8'hFF); bus_wr(5, 8'h00);

        // R9 test mode override
        bus_wr(9, 8'h0F); bus_wr(0, 8'h33); bus_wr(1, 8'hF0);
        @(negedge pclk); per_out = 8'h5A; per_oe_n = 8'h00;
        bus_wr(11, 8'hA5); bus_wr(12, 8'h69); bus_wr(13, 8'hC3); bus_wr(14, 8'h81);
        bus_wr(10, 8'h01); settle(1);
        check("R9 pad_out", pad_out, 8'hA5);
        check("R9 pad_oe_n", pad_oe_n, 8'h69);
        check("R9 per_in", per_in, 8'hC3);
        check("R9 irq_mis", irq_mis, 8'h81);
        check("R9 irq_any bit1 low", irq_any, 0);
        bus_wr(10, 8'h03); settle(1);
        check("R9 irq_any bit1 high", irq_any, 1);
        bus_wr(10, 8'h00); settle(1);
        check("R9 restored pad_out", pad_out, exp_pad(8'h0F, 8'h33, 8'h5A));
        check("R9 restored per_in", per_in, pad_in);

        // R10 unmapped offsets
        bus_rd(20, rd);  check("R10 unmapped read", rd, 8'h00);
        bus_rd(1023, rd); check("R10 top offset read", rd, 8'h00);
        bus_wr(20, 8'hFF); bus_wr(1023, 8'hFF); settle(1);
        bus_rd(1, rd); check("R10 dir untouched", rd, 8'hF0);
        check("R10 pad_out untouched", pad_out, exp_pad(8'h0F, 8'h33, 8'h5A));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule